// File: doc/BRIEF.md
# Low-Address Protection and Prefix Relocation Unit

This block sits in the address path of a processor core, after dynamic address translation has produced a real address. It takes one access request per cycle. For each request it does three things. It decides whether the access hits the protected low-storage area and must be refused. It relocates the resulting page address between the first 8 KiB of storage and the processor's prefix area. It assembles the translation-exception code that the core stores when an access fault is reported.

Table walking is handled elsewhere, so this block takes the page-aligned request address as the real address, whatever the translation state. The result is registered. It appears one cycle after the request and stays on the outputs until the next request is accepted.

Top module: `lap_prefix_unit`

## Requirements
- R1: A byte address is protected-low when it lies in 0 to 511 or in 4096 to 4607 inclusive. With protection active, a store to such a byte sets `prot_fault`. A store to 512 or to 4608 does not.
- R2: When `lap_enable` is 0, no access faults and `write_inval` stays 0.
- R3: With `dat_on` = 1, protection is active only when the private bit of the selected space is 0. The selector codes are 0 primary, 2 secondary and 3 home. With `dat_on` = 0, protection is active whenever `lap_enable` = 1.
- R4: A page address below 0x2000 is relocated to that address plus the prefix. Prefix bits 12:0 are ignored.
- R5: A page address in [prefix, prefix+0x2000) is relocated to that address minus the prefix.
- R6: Any other page address reaches `abs_addr` unchanged.
- R7: When protection is active and the page-aligned address is protected-low, `write_inval` is 1 for every access kind, including accesses that do not fault.
- R8: The exception code is the page-aligned address, OR 0x800 for a load (kind 0) or a fetch (kind 2), OR 0x400 for a store (kind 1), OR the 2-bit space selector in bits 1:0.
- R9: On a protection fault, `tec` also has bit 0x80 set, all three permission outputs are 0, and `abs_addr` is 0.
- R10: Without a fault, read, write and execute permissions are all 1. `abs_addr` is computed from the page-aligned address, so the byte offset is dropped.
- R11: `rsp_valid` pulses high for one cycle, one cycle after `req_valid`. The result outputs hold their values until the next request.
- R12: Synchronous reset clears every output to 0.
- R13: Selector 1 (access-register mode) with `dat_on` = 1 raises `mode_err`. In that case protection is treated as inactive. With `dat_on` = 0 the selector raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Request address (byte granular) |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lap_enable | input | 1 | Low-address protection control bit |
| dat_on | input | 1 | Translation-enable state |
| space_sel | input | 2 | Address-space selector: 0 primary, 1 access-register, 2 secondary, 3 home |
| priv_primary | input | 1 | Private-space bit of the primary space |
| priv_secondary | input | 1 | Private-space bit of the secondary space |
| priv_home | input | 1 | Private-space bit of the home space |
| prefix | input | 64 | Prefix register (8 KiB aligned) |
| rsp_valid | output | 1 | Result strobe |
| abs_addr | output | 64 | Absolute page address |
| perm_read | output | 1 | Read permitted |
| perm_write | output | 1 | Write permitted |
| perm_exec | output | 1 | Execute permitted |
| write_inval | output | 1 | Do-not-cache-for-write hint |
| prot_fault | output | 1 | Protection exception |
| tec | output | 64 | Translation-exception code |
| mode_err | output | 1 | Unsupported address-space mode |

## Verification
A wrong choice of space or a wrong private-bit select shows up at once on `prot_fault`, on the very response that follows the request. The same holds for an off-by-one in the low-range bounds. The bench therefore probes each range edge and each selector on its own. A relocation error appears in `abs_addr` in the response cycle. The bench probes both sides of the swap and the addresses just outside each window. If the response register took updates while no request was made, it would corrupt the held result. That error is caught two cycles after the inputs move with `req_valid` low.

// File: rtl/lap_pkg.sv
package lap_pkg;
    localparam int ADDR_W    = 64;
    localparam int PAGE_BITS = 12;
    localparam int WIN_BITS  = 13;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SP_PRIMARY   = 2'd0,
        SP_ACCREG    = 2'd1,
        SP_SECONDARY = 2'd2,
        SP_HOME      = 2'd3
    } space_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic [ADDR_W-1:0] abs_addr;
        perm_t             perm;
        logic              inval;
        logic              fault;
        logic [ADDR_W-1:0] tec;
        logic              mode_err;
    } resp_t;

    localparam logic [ADDR_W-1:0] TEC_FETCH_BIT = 64'h800;
    localparam logic [ADDR_W-1:0] TEC_STORE_BIT = 64'h400;
    localparam logic [ADDR_W-1:0] TEC_LOW_BIT   = 64'h80;

    function automatic logic [ADDR_W-1:0] build_tec(
        input logic [ADDR_W-1:0] page,
        input logic              is_store,
        input logic [1:0]        space,
        input logic              low_fault
    );
        logic [ADDR_W-1:0] code;
        code = page | (is_store ? TEC_STORE_BIT : TEC_FETCH_BIT)
                    | {{(ADDR_W-2){1'b0}}, space};
        if (low_fault) code = code | TEC_LOW_BIT;
        return code;
    endfunction
endpackage

// File: rtl/lap_check.sv
module lap_check
    import lap_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int PB        = PAGE_BITS,
    parameter int LOW_BYTES = 512
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    kind,
    input  logic          lap_enable,
    input  logic          dat_on,
    input  logic [1:0]    space,
    input  logic          priv_p,
    input  logic          priv_s,
    input  logic          priv_h,
    output logic          write_inval,
    output logic          fault,
    output logic          mode_err
);
    localparam int LOW_W = $clog2(LOW_BYTES);

    function automatic logic in_low(input logic [AW-1:0] a);
        return (a[AW-1:PB+1] == '0) && (a[PB-1:LOW_W] == '0);
    endfunction

    logic [AW-1:0] page;
    logic          priv_sel;
    logic          lap_on;

    assign page = {addr[AW-1:PB], {PB{1'b0}}};

    always_comb begin
        case (space_e'(space))
            SP_PRIMARY:   priv_sel = priv_p;
            SP_SECONDARY: priv_sel = priv_s;
            SP_HOME:      priv_sel = priv_h;
            default:      priv_sel = 1'b1;
        endcase
    end

    assign mode_err    = dat_on && (space_e'(space) == SP_ACCREG);
    assign lap_on      = lap_enable && (!dat_on || (!mode_err && !priv_sel));
    assign write_inval = lap_on && in_low(page);
    assign fault       = write_inval && in_low(addr) && (acc_kind_e'(kind) == ACC_STORE);
endmodule

// File: rtl/prefix_reloc.sv
module prefix_reloc
    import lap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WB = WIN_BITS
) (
    input  logic [AW-1:0] real_addr,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] abs_addr
);
    localparam logic [AW:0] WIN = (AW+1)'(1) << WB;
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW)'(1) << WB) + (AW)'(1);

    logic [AW-1:0] pfx;
    logic [AW:0]   pfx_ext;
    logic [AW:0]   real_ext;
    logic          in_zero;
    logic          in_pfx;

    assign pfx      = prefix & ALIGN_MASK;
    assign pfx_ext  = {1'b0, pfx};
    assign real_ext = {1'b0, real_addr};
    assign in_zero  = real_ext < WIN;
    assign in_pfx   = (real_ext >= pfx_ext) && (real_ext < pfx_ext + WIN);

    always_comb begin
        if (in_zero)      abs_addr = real_addr + pfx;
        else if (in_pfx)  abs_addr = real_addr - pfx;
        else              abs_addr = real_addr;
    end
endmodule

// File: rtl/lap_prefix_unit.sv
module lap_prefix_unit
    import lap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [63:0] req_addr,
    input  logic [1:0]  req_kind,
    input  logic        lap_enable,
    input  logic        dat_on,
    input  logic [1:0]  space_sel,
    input  logic        priv_primary,
    input  logic        priv_secondary,
    input  logic        priv_home,
    input  logic [63:0] prefix,
    output logic        rsp_valid,
    output logic [63:0] abs_addr,
    output logic        perm_read,
    output logic        perm_write,
    output logic        perm_exec,
    output logic        write_inval,
    output logic        prot_fault,
    output logic [63:0] tec,
    output logic        mode_err
);
    logic [ADDR_W-1:0] page;
    logic [ADDR_W-1:0] reloc;
    logic              c_inval, c_fault, c_mode;
    resp_t             nxt, cur;

    assign page = {req_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

    lap_check #(.AW(ADDR_W), .PB(PAGE_BITS), .LOW_BYTES(512)) u_check (
        .addr(req_addr), .kind(req_kind), .lap_enable(lap_enable),
        .dat_on(dat_on), .space(space_sel), .priv_p(priv_primary),
        .priv_s(priv_secondary), .priv_h(priv_home),
        .write_inval(c_inval), .fault(c_fault), .mode_err(c_mode)
    );

    prefix_reloc #(.AW(ADDR_W), .WB(WIN_BITS)) u_reloc (
        .real_addr(page), .prefix(prefix), .abs_addr(reloc)
    );

    always_comb begin
        nxt.abs_addr = c_fault ? '0 : reloc;
        nxt.perm     = c_fault ? 3'b000 : 3'b111;
        nxt.inval    = c_inval;
        nxt.fault    = c_fault;
        nxt.tec      = build_tec(page, acc_kind_e'(req_kind) == ACC_STORE, space_sel, c_fault);
        nxt.mode_err = c_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign abs_addr    = cur.abs_addr;
    assign perm_read   = cur.perm.r;
    assign perm_write  = cur.perm.w;
    assign perm_exec   = cur.perm.x;
    assign write_inval = cur.inval;
    assign prot_fault  = cur.fault;
    assign tec         = cur.tec;
    assign mode_err    = cur.mode_err;

    p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(abs_addr) && $stable(tec) && $stable(prot_fault) && !rsp_valid));
    p_fault_code_r9: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> (tec[10] && tec[7] && !tec[11] && abs_addr == '0));
    p_fault_needs_inval_r7: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> write_inval);
    p_mode_no_prot_r13: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (!prot_fault && !write_inval));
    p_kind_bits_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones(tec[11:10]) == 1));
endmodule

// File: tb/lap_prefix_unit_tb.sv
module lap_prefix_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_addr;
    logic [1:0]  req_kind;
    logic        lap_enable, dat_on;
    logic [1:0]  space_sel;
    logic        priv_primary, priv_secondary, priv_home;
    logic [63:0] prefix;
    logic        rsp_valid, perm_read, perm_write, perm_exec;
    logic        write_inval, prot_fault, mode_err;
    logic [63:0] abs_addr, tec;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lap_prefix_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .lap_enable(lap_enable), .dat_on(dat_on),
        .space_sel(space_sel), .priv_primary(priv_primary),
        .priv_secondary(priv_secondary), .priv_home(priv_home),
        .prefix(prefix), .rsp_valid(rsp_valid), .abs_addr(abs_addr),
        .perm_read(perm_read), .perm_write(perm_write), .perm_exec(perm_exec),
        .write_inval(write_inval), .prot_fault(prot_fault), .tec(tec),
        .mode_err(mode_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic en, input logic dat, input logic [1:0] sp,
                           input logic pp, input logic ps, input logic ph);
        lap_enable = en; dat_on = dat; space_sel = sp;
        priv_primary = pp; priv_secondary = ps; priv_home = ph;
    endtask

    task automatic issue(input logic [63:0] a, input logic [1:0] k);
        @(negedge clk);
        req_addr = a; req_kind = k; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R12 abs", abs_addr, 64'd0);
        check("R12 tec", tec, 64'd0);
        check("R12 flags", {57'd0, perm_read, perm_write, perm_exec, write_inval, prot_fault, mode_err, 1'b0}, 64'd0);
    endtask

    task automatic t_low_range;
        set_ctl(1, 0, 2'd0, 0, 0, 0);
        prefix = 64'h40000;
        issue(64'h1FF, 2'd1);
        check("R1 store 511 fault", {63'd0, prot_fault}, 64'd1);
        check("R9 fault tec", tec, 64'h480);
        check("R9 perms cleared", {61'd0, perm_read, perm_write, perm_exec}, 64'd0);
        check("R9 abs zero", abs_addr, 64'd0);
        issue(64'h200, 2'd1);
        check("R1 store 512 no fault", {63'd0, prot_fault}, 64'd0);
        check("R7 inval on page 0", {63'd0, write_inval}, 64'd1);
        issue(64'h1000, 2'd1);
        check("R1 store 4096 fault", {63'd0, prot_fault}, 64'd1);
        check("R9 tec page1", tec, 64'h1480);
        issue(64'h11FF, 2'd1);
        check("R1 store 4607 fault", {63'd0, prot_fault}, 64'd1);
        issue(64'h1200, 2'd1);
        check("R1 store 4608 no fault", {63'd0, prot_fault}, 64'd0);
        check("R7 inval on page 1", {63'd0, write_inval}, 64'd1);
    endtask

    task automatic t_enable_off;
        set_ctl(0, 0, 2'd0, 0, 0, 0);
        issue(64'h10, 2'd1);
        check("R2 no fault", {63'd0, prot_fault}, 64'd0);
        check("R2 no inval", {63'd0, write_inval}, 64'd0);
        check("R10 perms", {61'd0, perm_read, perm_write, perm_exec}, 64'd7);
    endtask

    task automatic t_spaces;
        set_ctl(1, 1, 2'd0, 1, 0, 0);
        issue(64'h10, 2'd1);
        check("R3 primary private", {63'd0, prot_fault}, 64'd0);
        set_ctl(1, 1, 2'd0, 0, 1, 1);
        issue(64'h10, 2'd1);
        check("R3 primary public", {63'd0, prot_fault}, 64'd1);
        set_ctl(1, 1, 2'd2, 0, 1, 0);
        issue(64'h10, 2'd1);
        check("R3 secondary private", {63'd0, prot_fault}, 64'd0);
        set_ctl(1, 1, 2'd3, 1, 1, 0);
        issue(64'h10, 2'd1);
        check("R3 home public", {63'd0, prot_fault}, 64'd1);
        check("R8 tec home", tec, 64'h483);
        set_ctl(1, 0, 2'd2, 1, 1, 1);
        issue(64'h10, 2'd1);
        check("R3 dat off ignores private", {63'd0, prot_fault}, 64'd1);
    endtask

    task automatic t_prefix;
        set_ctl(0, 0, 2'd0, 0, 0, 0);
        prefix = 64'h40FFF;
        issue(64'h1234, 2'd0);
        check("R4 low to prefix", abs_addr, 64'h41000);
        check("R8 load tec", tec, 64'h1800);
        issue(64'h41ABC, 2'd0);
        check("R5 prefix to low", abs_addr, 64'h1000);
        issue(64'h40000, 2'd2);
        check("R5 prefix base", abs_addr, 64'h0);
        issue(64'h42000, 2'd0);
        check("R6 above window", abs_addr, 64'h42000);
        issue(64'h2000, 2'd0);
        check("R6 just past low", abs_addr, 64'h2000);
    endtask

    task automatic t_inval_load;
        set_ctl(1, 0, 2'd0, 0, 0, 0);
        prefix = 64'h40000;
        issue(64'h300, 2'd0);
        check("R7 load inval", {62'd0, write_inval, prot_fault}, 64'd2);
        check("R10 abs from page", abs_addr, 64'h40000);
    endtask

    task automatic t_codes;
        set_ctl(0, 1, 2'd2, 0, 0, 0);
        issue(64'h5678, 2'd2);
        check("R8 fetch tec", tec, 64'h5802);
        set_ctl(0, 1, 2'd3, 0, 0, 0);
        issue(64'h7000, 2'd1);
        check("R8 store tec", tec, 64'h7403);
    endtask

    task automatic t_hold;
        logic [63:0] prev;
        set_ctl(0, 0, 2'd0, 0, 0, 0);
        issue(64'h9000, 2'd0);
        check("R11 rsp one cycle after", {63'd0, rsp_valid}, 64'd1);
        prev = abs_addr;
        req_addr = 64'h33000;
        req_kind = 2'd1;
        prefix = 64'h80000;
        @(negedge clk);
        @(negedge clk);
        check("R11 rsp drops", {63'd0, rsp_valid}, 64'd0);
        check("R11 abs held", abs_addr, prev);
        check("R11 tec held", tec, 64'h9800);
    endtask

    task automatic t_mode;
        set_ctl(1, 1, 2'd1, 0, 0, 0);
        issue(64'h10, 2'd1);
        check("R13 mode err", {63'd0, mode_err}, 64'd1);
        check("R13 no fault", {62'd0, prot_fault, write_inval}, 64'd0);
        set_ctl(1, 0, 2'd1, 0, 0, 0);
        issue(64'h10, 2'd1);
        check("R13 dat off no err", {63'd0, mode_err}, 64'd0);
        check("R13 dat off fault tec", tec, 64'h481);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_addr = '0; req_kind = '0;
        prefix = '0;
        set_ctl(0, 0, 2'd0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_low_range();
        t_enable_off();
        t_spaces();
        t_prefix();
        t_inval_load();
        t_codes();
        t_hold();
        t_mode();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule